// File: doc/BRIEF.md
# Interprocessor mailbox control registers

This block is a small register bank that two agents share. A remote bus master reaches it through a slave-side access port. The local processor reaches it through a second port. Both ports read combinationally and write on the clock edge.

The bank holds the following state:
- A halt request, which suspends the local processor while the remote side loads its memory.
- Two doorbells, which raise local interrupts at fixed, unequal priority levels. Each doorbell is gated by an enable input that comes from a separate local control register.
- Four semaphore bits, each in the top bit of its own byte.
- One full byte for passing messages between bus masters without using DRAM.

The outputs are the halt request, one interrupt request per doorbell and an encoded 3-bit interrupt level.

Top module: `mbx_ctrl`

## Requirements
- R1: Control byte address 0, bit 0, is the halt flag. A remote write to address 0 loads it from wdata bit 0, and `halt_o` follows it from the next cycle until a remote write clears it. Local writes never change it.
- R2: A remote write to address 0 with bit 1 set marks the low doorbell pending. `irq_lo_o` equals pending AND `lo_en_i`, and the request maps to level 2.
- R3: A remote write to address 0 with bit 2 set marks the high doorbell pending. `irq_hi_o` equals pending AND `hi_en_i`, and the request maps to level 5.
- R4: When both doorbells are pending and enabled, `irq_lvl_o` is 5. With only the low request active it is 2.
- R5: Addresses 1 to 4 each hold one semaphore bit in bit 7, writable from either port. Bits 6..0 of those bytes read as zero.
- R6: Address 5 is an 8-bit message byte that either port can read and write in full.
- R7: A local write of 1 to bit 1 or bit 2 of address 0 clears that doorbell, so its request is low from the next cycle. Writing 0 from either side leaves a doorbell unchanged.
- R8: When both ports write the same register in one cycle, the remote write determines the result. A remote set beats a local clear.
- R9: `irq_lvl_o` is 0 whenever no enabled doorbell is pending.
- R10: Asynchronous active-low reset clears all registers and outputs to zero. Control byte bits 7..3 and addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rem_addr_i | input | 3 | Remote port register address |
| rem_we_i | input | 1 | Remote port write strobe |
| rem_wdata_i | input | 8 | Remote port write data |
| rem_rdata_o | output | 8 | Remote port read data |
| loc_addr_i | input | 3 | Local port register address |
| loc_we_i | input | 1 | Local port write strobe |
| loc_wdata_i | input | 8 | Local port write data |
| loc_rdata_o | output | 8 | Local port read data |
| lo_en_i | input | 1 | Low doorbell interrupt enable from local control |
| hi_en_i | input | 1 | High doorbell interrupt enable from local control |
| halt_o | output | 1 | Halt request to local processor |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lvl_o | output | 3 | Encoded level of highest active request |

## Verification
A remote doorbell set and a local acknowledge-clear can hit the same control bit in the same cycle. Two writes can also hit the same semaphore or message byte in the same cycle. Directed cycles drive both ports at one address with opposing data. Random cycles aim both ports at a narrow address range so that collisions recur. Each result is judged one cycle later against a bench model in which the remote write takes precedence.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned NUM_SEM  = 4;
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_SEM0   = 1;
  localparam int unsigned A_MSG    = A_SEM0 + NUM_SEM;
  localparam int unsigned B_HALT   = 0;
  localparam int unsigned B_DB_LO  = 1;
  localparam int unsigned B_DB_HI  = 2;
  localparam int unsigned LVL_LO   = 2;
  localparam int unsigned LVL_HI   = 5;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [DATA_W-1:0] wdata;
  } acc_t;

  typedef struct packed {
    logic               halt;
    logic               db_lo;
    logic               db_hi;
    logic [NUM_SEM-1:0] sem;
    logic [DATA_W-1:0]  msg;
  } regs_t;
endpackage

// File: rtl/mbx_regfile.sv
module mbx_regfile
  import mbx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  acc_t  rem_i,
  input  acc_t  loc_i,
  output regs_t regs_o
);
  localparam int unsigned SEM_BIT = DATA_W - 1;

  logic rem_ctrl, loc_ctrl, rem_msg, loc_msg;
  assign rem_ctrl = rem_i.we && (rem_i.addr == ADDR_W'(A_CTRL));
  assign loc_ctrl = loc_i.we && (loc_i.addr == ADDR_W'(A_CTRL));
  assign rem_msg  = rem_i.we && (rem_i.addr == ADDR_W'(A_MSG));
  assign loc_msg  = loc_i.we && (loc_i.addr == ADDR_W'(A_MSG));

  // halt: remote only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       regs_o.halt <= 1'b0;
    else if (rem_ctrl) regs_o.halt <= rem_i.wdata[B_HALT];
  end

  // doorbells: remote sets, local W1C, set dominates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o.db_lo <= 1'b0;
      regs_o.db_hi <= 1'b0;
    end else begin
      if (rem_ctrl && rem_i.wdata[B_DB_LO])      regs_o.db_lo <= 1'b1;
      else if (loc_ctrl && loc_i.wdata[B_DB_LO]) regs_o.db_lo <= 1'b0;
      if (rem_ctrl && rem_i.wdata[B_DB_HI])      regs_o.db_hi <= 1'b1;
      else if (loc_ctrl && loc_i.wdata[B_DB_HI]) regs_o.db_hi <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_SEM; k++) begin : g_sem
    logic rem_hit, loc_hit;
    assign rem_hit = rem_i.we && (rem_i.addr == ADDR_W'(A_SEM0 + k));
    assign loc_hit = loc_i.we && (loc_i.addr == ADDR_W'(A_SEM0 + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_o.sem[k] <= 1'b0;
      else if (rem_hit) regs_o.sem[k] <= rem_i.wdata[SEM_BIT];
      else if (loc_hit) regs_o.sem[k] <= loc_i.wdata[SEM_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      regs_o.msg <= '0;
    else if (rem_msg) regs_o.msg <= rem_i.wdata;
    else if (loc_msg) regs_o.msg <= loc_i.wdata;
  end
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
  import mbx_pkg::*;
(
  input  regs_t             regs_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL)) begin
      rdata_o[B_HALT]  = regs_i.halt;
      rdata_o[B_DB_LO] = regs_i.db_lo;
      rdata_o[B_DB_HI] = regs_i.db_hi;
    end else if (addr_i == ADDR_W'(A_MSG)) begin
      rdata_o = regs_i.msg;
    end else begin
      for (int k = 0; k < NUM_SEM; k++)
        if (addr_i == ADDR_W'(A_SEM0 + k)) rdata_o[DATA_W-1] = regs_i.sem[k];
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
(
  input  logic             db_lo_i,
  input  logic             db_hi_i,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  output logic             irq_lo_o,
  output logic             irq_hi_o,
  output logic [LVL_W-1:0] lvl_o
);
  assign irq_lo_o = db_lo_i & lo_en_i;
  assign irq_hi_o = db_hi_i & hi_en_i;

  always_comb begin
    if (irq_hi_o)      lvl_o = LVL_W'(LVL_HI);
    else if (irq_lo_o) lvl_o = LVL_W'(LVL_LO);
    else               lvl_o = '0;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rem_addr_i,
  input  logic              rem_we_i,
  input  logic [DATA_W-1:0] rem_wdata_i,
  output logic [DATA_W-1:0] rem_rdata_o,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic              loc_we_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  output logic [DATA_W-1:0] loc_rdata_o,
  input  logic              lo_en_i,
  input  logic              hi_en_i,
  output logic              halt_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o,
  output logic [LVL_W-1:0]  irq_lvl_o
);
  acc_t  rem_acc, loc_acc;
  regs_t regs;

  assign rem_acc = '{addr: rem_addr_i, we: rem_we_i, wdata: rem_wdata_i};
  assign loc_acc = '{addr: loc_addr_i, we: loc_we_i, wdata: loc_wdata_i};

  mbx_regfile i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rem_i  (rem_acc),
    .loc_i  (loc_acc),
    .regs_o (regs)
  );

  mbx_rdmux i_rd_rem (.regs_i(regs), .addr_i(rem_addr_i), .rdata_o(rem_rdata_o));
  mbx_rdmux i_rd_loc (.regs_i(regs), .addr_i(loc_addr_i), .rdata_o(loc_rdata_o));

  mbx_irq i_irq (
    .db_lo_i  (regs.db_lo),
    .db_hi_i  (regs.db_hi),
    .lo_en_i  (lo_en_i),
    .hi_en_i  (hi_en_i),
    .irq_lo_o (irq_lo_o),
    .irq_hi_o (irq_hi_o),
    .lvl_o    (irq_lvl_o)
  );

  assign halt_o = regs.halt;
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk
  import mbx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rem_addr_i,
  input logic              rem_we_i,
  input logic [DATA_W-1:0] rem_wdata_i,
  input logic [DATA_W-1:0] rem_rdata_o,
  input logic [ADDR_W-1:0] loc_addr_i,
  input logic              loc_we_i,
  input logic [DATA_W-1:0] loc_wdata_i,
  input logic              lo_en_i,
  input logic              hi_en_i,
  input logic              halt_o,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [LVL_W-1:0]  irq_lvl_o
);
  logic rem_ctrl, loc_ctrl;
  assign rem_ctrl = rem_we_i && (rem_addr_i == ADDR_W'(A_CTRL));
  assign loc_ctrl = loc_we_i && (loc_addr_i == ADDR_W'(A_CTRL));

  p_halt_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_ctrl |=> (halt_o == $past(rem_wdata_i[B_HALT])));
  p_halt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rem_ctrl |=> $stable(halt_o));
  p_lo_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_lo_o |-> lo_en_i);
  p_hi_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> hi_en_i);
  p_hi_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_o |-> (irq_lvl_o == LVL_W'(LVL_HI)));
  p_lo_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o && !irq_hi_o) |-> (irq_lvl_o == LVL_W'(LVL_LO)));
  p_sem_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_addr_i >= ADDR_W'(A_SEM0) && rem_addr_i < ADDR_W'(A_MSG))
      |-> (rem_rdata_o[DATA_W-2:0] == '0));
  p_hi_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_ctrl && loc_wdata_i[B_DB_HI] && !(rem_ctrl && rem_wdata_i[B_DB_HI]))
      |=> !irq_hi_o);
  p_rem_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_ctrl && rem_wdata_i[B_DB_LO]) |=> (irq_lo_o == lo_en_i));
  p_idle_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_lo_o && !irq_hi_o) |-> (irq_lvl_o == '0));
endmodule

bind mbx_ctrl mbx_ctrl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rem_addr_i  (rem_addr_i),
  .rem_we_i    (rem_we_i),
  .rem_wdata_i (rem_wdata_i),
  .rem_rdata_o (rem_rdata_o),
  .loc_addr_i  (loc_addr_i),
  .loc_we_i    (loc_we_i),
  .loc_wdata_i (loc_wdata_i),
  .lo_en_i     (lo_en_i),
  .hi_en_i     (hi_en_i),
  .halt_o      (halt_o),
  .irq_lo_o    (irq_lo_o),
  .irq_hi_o    (irq_hi_o),
  .irq_lvl_o   (irq_lvl_o)
);

// File: tb/test_mbx_ctrl.sv
`timescale 1ns/1ps
module test_mbx_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] rem_addr = '0, loc_addr = '0;
  logic       rem_we = 1'b0, loc_we = 1'b0;
  logic [7:0] rem_wdata = '0, loc_wdata = '0;
  logic [7:0] rem_rdata, loc_rdata;
  logic       lo_en = 1'b0, hi_en = 1'b0;
  logic       halt, irq_lo, irq_hi;
  logic [2:0] irq_lvl;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic       m_halt = 0, m_lo = 0, m_hi = 0;
  logic [3:0] m_sem = '0;
  logic [7:0] m_msg = '0;

  always #10 clk = ~clk;  // 50 MHz

  mbx_ctrl i_mbx_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .rem_addr_i(rem_addr), .rem_we_i(rem_we), .rem_wdata_i(rem_wdata), .rem_rdata_o(rem_rdata),
    .loc_addr_i(loc_addr), .loc_we_i(loc_we), .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata),
    .lo_en_i(lo_en), .hi_en_i(hi_en),
    .halt_o(halt), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .irq_lvl_o(irq_lvl)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {5'b0, m_hi, m_lo, m_halt};
      3'd1, 3'd2, 3'd3, 3'd4: return {m_sem[a-3'd1], 7'b0};
      3'd5: return m_msg;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1, 3'd2, 3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [2:0] m_lvl();
    if (m_hi && hi_en) return 3'd5;
    if (m_lo && lo_en) return 3'd2;
    return 3'd0;
  endfunction

  task automatic check_all();
    chk({7'b0, halt},   {7'b0, m_halt},         "R1");
    chk({7'b0, irq_lo}, {7'b0, m_lo & lo_en},   "R2");
    chk({7'b0, irq_hi}, {7'b0, m_hi & hi_en},   "R3");
    chk({5'b0, irq_lvl}, {5'b0, m_lvl()},       (m_lvl() == 0) ? "R9" : "R4");
    chk(rem_rdata, m_read(rem_addr), req_of(rem_addr));
    chk(loc_rdata, m_read(loc_addr), req_of(loc_addr));
  endtask

  task automatic cyc(input logic [2:0] ra, input logic rw, input logic [7:0] rd,
                     input logic [2:0] la, input logic lw, input logic [7:0] ld,
                     input logic le, input logic he);
    logic rc, lc, n_halt, n_lo, n_hi;
    logic [3:0] n_sem;
    logic [7:0] n_msg;
    @(negedge clk);
    rem_addr = ra; rem_we = rw; rem_wdata = rd;
    loc_addr = la; loc_we = lw; loc_wdata = ld;
    lo_en = le; hi_en = he;
    #1 check_all();
    rc = rw && ra == 3'd0;
    lc = lw && la == 3'd0;
    n_halt = rc ? rd[0] : m_halt;
    n_lo = (rc && rd[1]) ? 1'b1 : (lc && ld[1]) ? 1'b0 : m_lo;
    n_hi = (rc && rd[2]) ? 1'b1 : (lc && ld[2]) ? 1'b0 : m_hi;
    n_sem = m_sem;
    for (int k = 0; k < 4; k++) begin
      if (rw && ra == 3'(k + 1))      n_sem[k] = rd[7];
      else if (lw && la == 3'(k + 1)) n_sem[k] = ld[7];
    end
    n_msg = (rw && ra == 3'd5) ? rd : (lw && la == 3'd5) ? ld : m_msg;
    @(posedge clk);
    #1;
    m_halt = n_halt; m_lo = n_lo; m_hi = n_hi; m_sem = n_sem; m_msg = n_msg;
    rem_we = 1'b0; loc_we = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1357);
    void'($urandom(32'd1357));
    // R10 during and after reset
    #25;
    chk({halt, irq_lo, irq_hi, irq_lvl}, 6'b0, "R10");
    chk(rem_rdata, 8'h00, "R10");
    @(negedge clk) rst_ni = 1'b1;

    // R10: unmapped and ctrl upper bits read zero
    cyc(3'd6, 1'b1, 8'hFF, 3'd7, 1'b1, 8'hFF, 1'b1, 1'b1);
    cyc(3'd6, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk(rem_rdata, 8'h00, "R10");

    // R1: remote halt, local cannot clear
    cyc(3'd0, 1'b1, 8'h01, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk({7'b0, halt}, 8'h01, "R1");
    cyc(3'd7, 1'b0, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0);
    chk({7'b0, halt}, 8'h01, "R1");
    cyc(3'd0, 1'b1, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    chk({7'b0, halt}, 8'h00, "R1");

    // R2/R3/R4: both doorbells, gated by enables
    cyc(3'd0, 1'b1, 8'h06, 3'd0, 1'b0, 8'h00, 1'b1, 1'b1);
    chk({5'b0, irq_lvl}, 8'd5, "R4");
    cyc(3'd7, 1'b0, 8'h00, 3'd7, 1'b0, 8'h00, 1'b1, 1'b0);
    chk({5'b0, irq_lvl}, 8'd2, "R2");
    cyc(3'd7, 1'b0, 8'h00, 3'd7, 1'b0, 8'h00, 1'b0, 1'b0);
    chk({5'b0, irq_lvl}, 8'd0, "R9");
    // R7: writing 0 leaves doorbells, W1C clears hi only
    cyc(3'd0, 1'b1, 8'h00, 3'd0, 1'b1, 8'h00, 1'b1, 1'b1);
    chk({5'b0, irq_lvl}, 8'd5, "R7");
    cyc(3'd7, 1'b0, 8'h00, 3'd0, 1'b1, 8'h04, 1'b1, 1'b1);
    chk({7'b0, irq_hi}, 8'h00, "R7");
    chk({5'b0, irq_lvl}, 8'd2, "R3");

    // R8: remote set vs local clear on low doorbell
    cyc(3'd0, 1'b1, 8'h02, 3'd0, 1'b1, 8'h02, 1'b1, 1'b1);
    chk({7'b0, irq_lo}, 8'h01, "R8");
    // R8: message byte collision
    cyc(3'd5, 1'b1, 8'hA5, 3'd5, 1'b1, 8'h5A, 1'b1, 1'b1);
    chk(loc_rdata, 8'hA5, "R8");
    // R8: semaphore collision
    cyc(3'd3, 1'b1, 8'h00, 3'd3, 1'b1, 8'hFF, 1'b1, 1'b1);
    chk(rem_rdata, 8'h00, "R8");
    // R5: local sets semaphore, low bits masked
    cyc(3'd7, 1'b0, 8'h00, 3'd2, 1'b1, 8'hFF, 1'b1, 1'b1);
    cyc(3'd2, 1'b0, 8'h00, 3'd2, 1'b0, 8'h00, 1'b1, 1'b1);
    chk(rem_rdata, 8'h80, "R5");
    // R6: local writes message, remote reads
    cyc(3'd7, 1'b0, 8'h00, 3'd5, 1'b1, 8'h3C, 1'b1, 1'b1);
    cyc(3'd5, 1'b0, 8'h00, 3'd7, 1'b0, 8'h00, 1'b1, 1'b1);
    chk(rem_rdata, 8'h3C, "R6");

    // random mix, narrow address range for collisions
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ra, la;
      ra = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2 == 0 ? 0 : 5);
      la = ($urandom % 3 == 0) ? ra : 3'($urandom);
      cyc(ra, 1'($urandom), 8'($urandom), la, 1'($urandom), 8'($urandom),
          1'($urandom), 1'($urandom));
    end

    // R10: reset in the middle clears state
    cyc(3'd0, 1'b1, 8'h07, 3'd5, 1'b1, 8'hFF, 1'b1, 1'b1);
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk({halt, irq_lo, irq_hi, irq_lvl}, 6'b0, "R10");
    loc_addr = 3'd5;
    #1 chk(loc_rdata, 8'h00, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule